// File: doc/BRIEF.md
# Lockstep Life Cell Array

This block is a square mesh of one-bit cells that all follow the Life birth and survival rule at the same time, under one shared controller. Each cell keeps a single live or dead bit. It looks at its eight surrounding cells, adds up how many are live, and applies the rule. Every cell's new value is committed on the same clock edge, so the array advances exactly one generation per cycle.

A host first writes the starting pattern one row at a time through a row-parallel load port. It then pulses `start`. The controller clears its generation counter and lets the array step. Stepping ends in one of two ways: a global OR over all cells finds no live cell left, or the counter reaches the cap `MAX_GEN`. When stepping ends, `done` pulses for one cycle and the number of generations applied stays on `gen_count`. The whole grid is visible on `cells` at all times.

Top module: `life_array`

## Requirements
- R1: Each cell adds up the live states of its eight neighbours (north, north-east, east, south-east, south, south-west, west, north-west). Positions outside the grid count as dead, and there is no wraparound.
- R2: A live cell stays live only when its neighbour count is 2 or 3. Otherwise it becomes dead.
- R3: A dead cell becomes live only when its neighbour count is exactly 3.
- R4: All cells commit their next state on the same edge, one generation per cycle while running. `done` is first seen high G+1 clock edges after the edge that accepted `start`, where G is the final count.
- R5: Stepping stops as soon as no cell is live. If the loaded pattern is empty, `done` is raised with a count of 0 and no generation is applied.
- R6: Stepping stops when the count reaches `MAX_GEN` (default 1000). The count never goes above `MAX_GEN`.
- R7: `done` is high for exactly one cycle. `gen_count` keeps the final count until the next accepted `start`.
- R8: While idle, `load_en` writes `load_row` into row `load_addr`. Bit c of `load_row` is column c, and cell (row r, column c) appears on `cells[r*GRID_N+c]`, with row 0 on the north edge and column 0 on the west edge. A load while busy is ignored.
- R9: A `start` pulse while idle clears the count and begins stepping. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all cells and the counter |
| start | input | 1 | Begin stepping from the loaded pattern |
| load_en | input | 1 | Write one row of the pattern |
| load_addr | input | $clog2(GRID_N) | Row index for the write |
| load_row | input | GRID_N | Row contents, bit c is column c |
| busy | output | 1 | High while generations are being stepped |
| done | output | 1 | One-cycle pulse when stepping halts |
| gen_count | output | CNT_W | Generations applied since the last start |
| cells | output | GRID_N*GRID_N | Current state of every cell |

## Verification
The array is run on several patterns, and each result is compared with an independent behavioural model of the rule. An empty grid and a lone cell check the immediate stop and a stop after one generation. A blinker and a block both run to the cap, one oscillating and one still, so phase errors and survival errors show up in the final grid. Blinkers lying along the north and east borders die in two generations only if the edge reads as dead, and wraparound would keep them alive. A corner L-shape that grows into a block tests births on the border. Random dense patterns mix all the rule cases. A blinker run that receives a stray load and a stray start partway through checks that both are ignored while busy.

// File: rtl/life_pkg.sv
package life_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ctrl_state_e;

   // number of live neighbours among eight inputs
   function automatic logic [3:0] nbr_total(input logic [7:0] nb);
      logic [3:0] acc;
      acc = '0;
      for (int i = 0; i < 8; i++) begin
         acc = acc + {3'b000, nb[i]};
      end
      return acc;
   endfunction

   // birth on three, survival on two or three
   function automatic logic life_rule(input logic cur, input logic [3:0] total);
      logic nxt;
      if (cur) nxt = (total == 4'd2) || (total == 4'd3);
      else     nxt = (total == 4'd3);
      return nxt;
   endfunction

endpackage

// File: rtl/life_cell.sv
module life_cell
   import life_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] nbr_i,
   input  logic       load_we_i,
   input  logic       load_val_i,
   input  logic       step_i,
   output logic       state_o
);

   logic [3:0] total;
   logic       next_state;

   always_comb begin
      total      = nbr_total(nbr_i);
      next_state = life_rule(state_o, total);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         state_o <= 1'b0;
      else if (load_we_i) state_o <= load_val_i;
      else if (step_i)    state_o <= next_state;
   end

endmodule

// File: rtl/life_grid.sv
module life_grid #(
   parameter int GRID_N = 16,
   localparam int AW    = (GRID_N > 1) ? $clog2(GRID_N) : 1,
   localparam int NCELL = GRID_N * GRID_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic [AW-1:0]     load_addr,
   input  logic [GRID_N-1:0] load_row,
   input  logic              step,
   output logic [NCELL-1:0]  cells,
   output logic              any_alive
);

   // grid surrounded by a ring of constant dead cells
   logic [GRID_N+1:0][GRID_N+1:0] pad;
   logic [GRID_N-1:0]             row_we;
   logic [GRID_N-1:0]             row_any;

   always_comb begin
      pad = '0;
      for (int r = 0; r < GRID_N; r++) begin
         for (int c = 0; c < GRID_N; c++) begin
            pad[r+1][c+1] = cells[r*GRID_N + c];
         end
      end
   end

   for (genvar r = 0; r < GRID_N; r++) begin : g_row
      assign row_we[r]  = load_we && (load_addr == AW'(r));
      assign row_any[r] = |cells[r*GRID_N +: GRID_N];

      for (genvar c = 0; c < GRID_N; c++) begin : g_col
         logic [7:0] nb;
         // order: N, NE, E, SE, S, SW, W, NW
         assign nb = {pad[r][c+1],   pad[r][c+2],   pad[r+1][c+2], pad[r+2][c+2],
                      pad[r+2][c+1], pad[r+2][c],   pad[r+1][c],   pad[r][c]};

         life_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .nbr_i      (nb),
            .load_we_i  (row_we[r]),
            .load_val_i (load_row[c]),
            .step_i     (step),
            .state_o    (cells[r*GRID_N + c])
         );
      end
   end

   assign any_alive = |row_any;

endmodule

// File: rtl/life_ctrl.sv
module life_ctrl
   import life_pkg::*;
#(
   parameter int MAX_GEN = 1000,
   parameter int CNT_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             any_alive,
   output logic             step,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_GEN);

   ctrl_state_e st;

   assign busy = (st == ST_RUN);
   assign step = busy && any_alive && (count != CAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         done  <= 1'b0;
         count <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  count <= '0;
                  st    <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (step) begin
                  count <= count + 1'b1;
               end else begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/life_array.sv
module life_array #(
   parameter int GRID_N  = 16,
   parameter int MAX_GEN = 1000,
   localparam int AW     = (GRID_N > 1) ? $clog2(GRID_N) : 1,
   localparam int CW_RAW = $clog2(MAX_GEN + 1),
   localparam int CNT_W  = (CW_RAW > 10) ? CW_RAW : 10,
   localparam int NCELL  = GRID_N * GRID_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              load_en,
   input  logic [AW-1:0]     load_addr,
   input  logic [GRID_N-1:0] load_row,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  gen_count,
   output logic [NCELL-1:0]  cells
);

   if (GRID_N < 3) begin : g_bad_grid
      $error("life_array: GRID_N must be at least 3");
   end
   if (MAX_GEN < 1) begin : g_bad_cap
      $error("life_array: MAX_GEN must be at least 1");
   end

   logic step_w;
   logic alive_w;
   logic load_we_w;

   assign load_we_w = load_en && !busy;

   life_grid #(.GRID_N(GRID_N)) u_grid (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (load_we_w),
      .load_addr (load_addr),
      .load_row  (load_row),
      .step      (step_w),
      .cells     (cells),
      .any_alive (alive_w)
   );

   life_ctrl #(.MAX_GEN(MAX_GEN), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .any_alive (alive_w),
      .step      (step_w),
      .busy      (busy),
      .done      (done),
      .count     (gen_count)
   );

endmodule

// File: rtl/life_array_chk.sv
module life_array_chk #(
   parameter int GRID_N  = 16,
   parameter int MAX_GEN = 1000,
   parameter int CNT_W   = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic                     load_en,
   input logic                     busy,
   input logic                     done,
   input logic [CNT_W-1:0]         gen_count,
   input logic [GRID_N*GRID_N-1:0] cells,
   input logic                     step_w,
   input logic                     alive_w
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_GEN);

   p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gen_count <= CAP);

   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(gen_count));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step_w |=> (gen_count == $past(gen_count) + 1'b1));

   p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!$past(alive_w) || ($past(gen_count) == CAP)));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_en) |=> $stable(cells));

   p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && gen_count == '0));

endmodule

bind life_array life_array_chk #(
   .GRID_N  (GRID_N),
   .MAX_GEN (MAX_GEN),
   .CNT_W   (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .load_en   (load_en),
   .busy      (busy),
   .done      (done),
   .gen_count (gen_count),
   .cells     (cells),
   .step_w    (step_w),
   .alive_w   (alive_w)
);

// File: tb/life_array_tb.sv
module life_array_tb;

   localparam int N     = 16;
   localparam int MAXG  = 1000;
   localparam int AW    = 4;
   localparam int CW    = 10;
   localparam int NC    = N * N;

   typedef struct {
      int          cnt;
      logic [NC-1:0] grid;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [N-1:0]  load_row = '0;
   logic          busy, done;
   logic [CW-1:0] gen_count;
   logic [NC-1:0] cells;

   int   n_checks = 0;
   int   n_errs   = 0;
   bit   finished = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   life_array #(.GRID_N(N), .MAX_GEN(MAXG)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
      .load_addr(load_addr), .load_row(load_row), .busy(busy), .done(done),
      .gen_count(gen_count), .cells(cells)
   );

   task automatic chk_int(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_grid(input string req, input string what, input logic [NC-1:0] act,
                           input logic [NC-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // behavioural model of one generation, edges read as dead
   function automatic logic [NC-1:0] model_step(input logic [NC-1:0] g);
      logic [NC-1:0] nx;
      nx = '0;
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < N; c++) begin
            int s;
            s = 0;
            for (int dr = -1; dr <= 1; dr++) begin
               for (int dc = -1; dc <= 1; dc++) begin
                  if ((dr != 0 || dc != 0) && r+dr >= 0 && r+dr < N && c+dc >= 0 && c+dc < N)
                     s += int'(g[(r+dr)*N + c+dc]);
               end
            end
            if (g[r*N+c]) nx[r*N+c] = (s == 2 || s == 3);
            else          nx[r*N+c] = (s == 3);
         end
      end
      return nx;
   endfunction

   function automatic logic [NC-1:0] put(input logic [NC-1:0] g, input int r, input int c);
      logic [NC-1:0] o;
      o = g;
      o[r*N+c] = 1'b1;
      return o;
   endfunction

   // monitor: compares each completion with the queued expectation
   always @(negedge clk) begin
      if (rst_n && done && !finished) begin
         if (exp_q.size() == 0) begin
            chk_int("R7", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk_int("R5 R6", {e.tag, " final count"}, int'(gen_count), e.cnt);
            chk_grid("R1 R2 R3", {e.tag, " final grid"}, cells, e.grid);
         end
      end
   end

   task automatic run_case(input logic [NC-1:0] g, input string tag, input bit disturb);
      exp_t e;
      logic [NC-1:0] m;
      int cnt;
      int lat;
      // R8: row-parallel load
      for (int r = 0; r < N; r++) begin
         @(negedge clk);
         load_en   = 1'b1;
         load_addr = AW'(r);
         load_row  = g[r*N +: N];
      end
      @(negedge clk);
      load_en = 1'b0;
      chk_grid("R8", {tag, " loaded grid"}, cells, g);
      m = g;
      cnt = 0;
      while (m != '0 && cnt < MAXG) begin
         m = model_step(m);
         cnt++;
      end
      e.cnt = cnt; e.grid = m; e.tag = tag;
      exp_q.push_back(e);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      forever begin
         @(negedge clk);
         lat++;
         load_en = 1'b0;
         start   = 1'b0;
         if (done || lat > MAXG + 20) break;
         if (disturb && lat == 3) begin
            // R8, R9: both must be ignored while busy
            load_en   = 1'b1;
            load_addr = '0;
            load_row  = '1;
            start     = 1'b1;
         end
      end
      chk_int("R4", {tag, " latency"}, lat, cnt + 1);
      @(negedge clk);
      chk_int("R7", {tag, " done width"}, int'(done), 0);
      chk_int("R7", {tag, " count held"}, int'(gen_count), cnt);
   endtask

   initial begin
      logic [NC-1:0] g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_int("R7", "reset busy", int'(busy), 0);
      chk_int("R7", "reset done", int'(done), 0);
      chk_int("R6", "reset count", int'(gen_count), 0);
      chk_grid("R8", "reset grid", cells, '0);

      run_case('0, "empty R5", 1'b0);
      run_case(put('0, 7, 7), "single cell R2", 1'b0);
      g = put(put(put('0, 6, 7), 7, 7), 8, 7);
      run_case(g, "blinker cap R6", 1'b0);
      g = put(put(put(put('0, 4, 4), 4, 5), 5, 4), 5, 5);
      run_case(g, "block R2", 1'b0);
      g = put(put(put('0, 0, 4), 0, 5), 0, 6);
      run_case(g, "north edge R1", 1'b0);
      g = put(put(put('0, 4, 15), 5, 15), 6, 15);
      run_case(g, "east edge R1", 1'b0);
      g = put(put(put('0, 0, 0), 0, 1), 1, 0);
      run_case(g, "corner birth R3", 1'b0);
      g = put(put(put('0, 10, 3), 10, 4), 10, 5);
      run_case(g, "busy ignore R9", 1'b1);
      for (int k = 0; k < 4; k++) begin
         g = '0;
         for (int i = 0; i < NC; i++) g[i] = (($urandom % 3) == 0);
         run_case(g, "random R3", 1'b0);
      end
      chk_int("R7", "queue drained", exp_q.size(), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule